// File: doc/BRIEF.md
# Flash Write Inhibit Gate

This block sits between the external bus pins of a NOR flash model and its command interface, and decides whether a bus write cycle is allowed through. The active-low strobes for chip enable, output enable and write enable are each filtered so that a low pulse shorter than a set number of clock cycles is ignored. A write is then reported to the command state machine as a single-cycle pulse when the filtered write enable is released while chip enable is held and output enable is not.

Several inhibit sources can suppress that pulse. These are a low program-enable level, a low-supply flag from an external comparator, and a power-up inhibit. The power-up inhibit is armed by the power-on reset pulse. It stays armed for as long as chip enable and the reset pin are held low with output enable high. The block also drives a global program/erase disable level. It also drives a reset request that puts the command state machine back to idle at power-up and holds it there while the supply is low. All inputs are sampled in the block's clock domain, and the glitch threshold is measured in clock cycles.

Top module: `flash_wr_gate`

## Requirements
- R1: While `rst` is high, `wr_pulse` is 0 and both `pe_disable` and `csm_reset` are 1.
- R2: A write is accepted when `we_n` is low for at least `GLITCH_CYC` (default 3) consecutive clock edges while `ce_n` is held low and `oe_n` high. Acceptance means `wr_pulse` is high for exactly one cycle. That cycle starts one clock edge after the first edge that sees `we_n` high.
- R3: A low pulse on `we_n` that lasts fewer than `GLITCH_CYC` edges produces no `wr_pulse`.
- R4: If `ce_n` is low for fewer than `GLITCH_CYC` edges during a write, no `wr_pulse` is produced. The same holds if `oe_n` is low during the write.
- R5: While `vpp_en` is 0, no write is accepted. `pe_disable` is 1 one edge after `vpp_en` falls and 0 one edge after it returns high.
- R6: While `vcc_low` is 1, no write is accepted and both `pe_disable` and `csm_reset` are 1 (one edge later). A write attempted during that time is not replayed after the flag clears.
- R7: After `por`, writes are rejected while `ce_n`=0, `rst_pin_n`=0 and `oe_n`=1 all hold. The first edge at which that condition fails ends the inhibit for good, and later writes are accepted even with `rst_pin_n` low.
- R8: A one-cycle `por` pulse makes `csm_reset` 1 on the following cycle. `csm_reset` returns to 0 one cycle later when `vcc_low` is 0.
- R9: A `we_n` low pulse of exactly `GLITCH_CYC` edges is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| rst_pin_n | input | 1 | Device reset pin level, active low |
| vpp_en | input | 1 | Program-enable level, 0 blocks program and erase |
| vcc_low | input | 1 | Supply-below-lockout flag from a comparator |
| por | input | 1 | Power-on reset pulse |
| wr_pulse | output | 1 | Qualified write strobe, one cycle per accepted write |
| pe_disable | output | 1 | Global program/erase disable |
| csm_reset | output | 1 | Reset-to-idle request to the command state machine |

## Verification
Write cycles are run over a spread of write-enable widths: well above, exactly at, one below and far below the threshold. A pulse count of 1 versus 0 shows where the filter boundary lies, and a count of 2 would expose a stretched strobe. The same write shape is repeated with a short chip-enable pulse, with output enable asserted, with the program-enable level low and with the supply flag raised. This separates each qualifier and each inhibit source from the others. A power-up sequence holding the strobe condition shows the inhibit is applied, and a second write after the condition is broken shows it is released for good.

// File: rtl/flash_wr_gate_pkg.sv
package flash_wr_gate_pkg;

    // Filtered strobes, 1 = asserted (pin low long enough)
    typedef struct packed {
        logic ce;
        logic oe;
        logic we;
    } strobe_t;

    // Independent reasons to drop a write
    typedef struct packed {
        logic vpp_off;
        logic supply_low;
        logic powerup;
    } inhibit_t;

    localparam int NUM_STROBES = 3;

    function automatic logic any_inhibit(inhibit_t i);
        return i.vpp_off | i.supply_low | i.powerup;
    endfunction

    // Strobe pattern that keeps the power-up inhibit armed
    function automatic logic powerup_hold(logic ce_n, logic oe_n, logic rst_pin_n);
        return (!ce_n) && (!rst_pin_n) && oe_n;
    endfunction

endpackage

// File: rtl/strobe_filter.sv
module strobe_filter #(
    parameter int GLITCH_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_n,
    output logic asserted
);
    localparam int CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            asserted <= 1'b0;
        end else if (raw_n) begin
            low_cnt  <= '0;
            asserted <= 1'b0;
        end else if (low_cnt == LAST) begin
            asserted <= 1'b1;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // R3: the filtered strobe is never asserted unless the pin was low at the last edge
    a_r3_filt_follows_low: assert property (@(posedge clk) disable iff (rst)
        asserted |-> !$past(raw_n));

endmodule

// File: rtl/pwrup_inhibit.sv
module pwrup_inhibit
    import flash_wr_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic ce_n,
    input  logic oe_n,
    input  logic rst_pin_n,
    output logic armed
);
    always_ff @(posedge clk) begin
        if (rst || por) begin
            armed <= 1'b1;
        end else if (armed && !powerup_hold(ce_n, oe_n, rst_pin_n)) begin
            armed <= 1'b0;
        end
    end

    // R7: once released, the inhibit stays released until the next power-on pulse
    a_r7_release_sticks: assert property (@(posedge clk) disable iff (rst)
        (!$past(armed) && !$past(por)) |-> !armed);

endmodule

// File: rtl/write_qual.sv
module write_qual
    import flash_wr_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  strobe_t  filt,
    input  inhibit_t inh,
    output logic     wr_pulse
);
    strobe_t filt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_d   <= '0;
            wr_pulse <= 1'b0;
        end else begin
            filt_d   <= filt;
            wr_pulse <= filt_d.we && !filt.we && filt_d.ce && !filt_d.oe
                        && !any_inhibit(inh);
        end
    end

    // R2: a qualified write lasts a single cycle
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);
    // R5: no write while program enable is low
    a_r5_vpp_blocks: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> !$past(inh.vpp_off));
    // R6: no write while supply is low
    a_r6_supply_blocks: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> !$past(inh.supply_low));
    // R7: no write while the power-up inhibit is armed
    a_r7_powerup_blocks: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> !$past(inh.powerup));

endmodule

// File: rtl/flash_wr_gate.sv
module flash_wr_gate
    import flash_wr_gate_pkg::*;
#(
    parameter int GLITCH_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic rst_pin_n,
    input  logic vpp_en,
    input  logic vcc_low,
    input  logic por,
    output logic wr_pulse,
    output logic pe_disable,
    output logic csm_reset
);
    logic [NUM_STROBES-1:0] pins_n;
    logic [NUM_STROBES-1:0] filt_vec;
    strobe_t  filt;
    inhibit_t inh;
    logic     pu_armed;

    assign pins_n = {ce_n, oe_n, we_n};

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_filt
        strobe_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
            .clk      (clk),
            .rst      (rst),
            .raw_n    (pins_n[g]),
            .asserted (filt_vec[g])
        );
    end

    assign filt = strobe_t'(filt_vec);

    pwrup_inhibit u_pwrup (
        .clk       (clk),
        .rst       (rst),
        .por       (por),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .rst_pin_n (rst_pin_n),
        .armed     (pu_armed)
    );

    always_comb begin
        inh.vpp_off    = !vpp_en;
        inh.supply_low = vcc_low;
        inh.powerup    = pu_armed;
    end

    write_qual u_qual (
        .clk      (clk),
        .rst      (rst),
        .filt     (filt),
        .inh      (inh),
        .wr_pulse (wr_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pe_disable <= 1'b1;
            csm_reset  <= 1'b1;
        end else begin
            pe_disable <= inh.vpp_off | inh.supply_low;
            csm_reset  <= por | inh.supply_low;
        end
    end

    // R6: a low supply always disables program/erase and holds the state machine
    a_r6_lockout_outputs: assert property (@(posedge clk) disable iff (rst)
        $past(vcc_low) |-> (pe_disable && csm_reset));
    // R8: power-on pulse requests a state machine reset
    a_r8_por_resets_csm: assert property (@(posedge clk) disable iff (rst)
        por |=> csm_reset);
    // R5: program enable low forces the global disable
    a_r5_vpp_disable: assert property (@(posedge clk) disable iff (rst)
        !$past(vpp_en) |-> pe_disable);

endmodule

// File: tb/flash_wr_gate_tb.sv
module flash_wr_gate_tb;
    localparam int GC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rst_pin_n = 1'b1;
    logic vpp_en = 1'b1, vcc_low = 1'b0, por = 1'b0;
    logic wr_pulse, pe_disable, csm_reset;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_wr_gate #(.GLITCH_CYC(GC)) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rst_pin_n(rst_pin_n), .vpp_en(vpp_en), .vcc_low(vcc_low), .por(por),
        .wr_pulse(wr_pulse), .pe_disable(pe_disable), .csm_reset(csm_reset)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One write cycle; returns the number of cycles wr_pulse was seen high
    task automatic do_write(input int we_len, input int ce_len, input bit oe_low,
                            output int pulses);
        pulses = 0;
        @(negedge clk);
        ce_n = 1'b0;
        we_n = 1'b0;
        oe_n = !oe_low;
        for (int i = 0; i < we_len; i++) begin
            @(negedge clk);
            pulses += int'(wr_pulse);
            if (i + 1 == ce_len) ce_n = 1'b1;
        end
        we_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            pulses += int'(wr_pulse);
            ce_n = 1'b1;
            oe_n = 1'b1;
        end
    endtask

    typedef struct packed {
        logic [7:0] we_len;
        logic [7:0] ce_len;
        logic       oe_low;
        logic       vpp;
        logic       vlo;
        logic [1:0] exp_n;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'd5, 8'd99, 1'b0, 1'b1, 1'b0, 2'd1, 4'd2},
        '{8'd3, 8'd99, 1'b0, 1'b1, 1'b0, 2'd1, 4'd9},
        '{8'd2, 8'd99, 1'b0, 1'b1, 1'b0, 2'd0, 4'd3},
        '{8'd1, 8'd99, 1'b0, 1'b1, 1'b0, 2'd0, 4'd3},
        '{8'd6, 8'd2,  1'b0, 1'b1, 1'b0, 2'd0, 4'd4},
        '{8'd5, 8'd99, 1'b1, 1'b1, 1'b0, 2'd0, 4'd4},
        '{8'd4, 8'd99, 1'b0, 1'b0, 1'b0, 2'd0, 4'd5},
        '{8'd4, 8'd99, 1'b0, 1'b1, 1'b1, 2'd0, 4'd6},
        '{8'd8, 8'd99, 1'b0, 1'b1, 1'b0, 2'd1, 4'd2}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int p;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 wr_pulse in reset", int'(wr_pulse), 0);
        chk("R1 pe_disable in reset", int'(pe_disable), 1);
        chk("R1 csm_reset in reset", int'(csm_reset), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pe_disable after reset", int'(pe_disable), 0);
        chk("R1 csm_reset after reset", int'(csm_reset), 0);
        repeat (2) @(negedge clk);

        // Table of write shapes and inhibit settings (R2 R3 R4 R5 R6 R9)
        for (int k = 0; k < NV; k++) begin
            vpp_en  = VECS[k].vpp;
            vcc_low = VECS[k].vlo;
            do_write(int'(VECS[k].we_len), int'(VECS[k].ce_len), VECS[k].oe_low, p);
            chk($sformatf("R%0d vector %0d pulses", VECS[k].req, k), p, int'(VECS[k].exp_n));
            vpp_en  = 1'b1;
            vcc_low = 1'b0;
            // R6: nothing replayed once the flag has cleared
            p = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                p += int'(wr_pulse);
            end
            chk("R6 no replay after vector", p, 0);
        end

        // R5: disable level follows program enable
        vpp_en = 1'b0;
        @(negedge clk);
        chk("R5 pe_disable with vpp low", int'(pe_disable), 1);
        vpp_en = 1'b1;
        @(negedge clk);
        chk("R5 pe_disable with vpp high", int'(pe_disable), 0);

        // R6: supply flag drives both disables
        vcc_low = 1'b1;
        @(negedge clk);
        chk("R6 pe_disable with supply low", int'(pe_disable), 1);
        chk("R6 csm_reset with supply low", int'(csm_reset), 1);
        vcc_low = 1'b0;
        @(negedge clk);
        chk("R6 csm_reset after supply ok", int'(csm_reset), 0);

        // R8: power-on pulse with the power-up strobe pattern held (R7)
        ce_n = 1'b0;
        oe_n = 1'b1;
        rst_pin_n = 1'b0;
        por = 1'b1;
        @(negedge clk);
        por = 1'b0;
        chk("R8 csm_reset after por", int'(csm_reset), 1);
        @(negedge clk);
        chk("R8 csm_reset released", int'(csm_reset), 0);

        // R7: write during power-up pattern is rejected
        do_write(5, 99, 1'b0, p);
        chk("R7 write rejected during power-up pattern", p, 0);
        // the task released ce_n, so the inhibit has ended
        do_write(5, 99, 1'b0, p);
        chk("R7 write accepted after pattern broken", p, 1);
        rst_pin_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule